// File: doc/BRIEF.md
# NAND Bank Select and Command Window

This block is the register front end that lets a host processor generate raw NAND flash bus cycles one byte at a time. A shared control register picks the active chip enable with a one-hot field, holds the write-protect pin level and shows the ready/busy state of the selected device. Each bank owns a small address window with three ports. A write to the command port becomes a CLE cycle, a write to the address port becomes an ALE cycle, and the data port gives plain data write cycles and RE_n read cycles.

The host uses a request/acknowledge bus that supports one outstanding access. A register access acknowledges on the next clock. An access that reaches the flash holds the host until the strobe sequence has finished. A timing register sets the setup, strobe-low and strobe-high phases in core clocks. The flash side is an 8-bit asynchronous bus with split data-in and data-out lanes and an output enable.

Top module: `nand_port_front`

## Requirements
- R1: After reset every nf_ce_n bit is high, nf_wp_n is high, nf_we_n and nf_re_n are high, and nf_cle and nf_ale are low. The control register (offset 0x000) reads 0x100 and the timing register (offset 0x004) reads 0x1081.
- R2: Control register bits [7:0] are chip enables, and bit n set drives nf_ce_n[n] low. Bit 8 drives nf_wp_n directly, so 1 means unprotected. Bit 9 is read-only, and a write to it has no effect.
- R3: Control bit 9 reads the nf_rb_n level of the selected bank, seen through a two-stage synchronizer. It reads 0 when no bank is selected.
- R4: A write to offset 0x08 of bank n's window (0x800 + n*0x100) produces one nf_we_n pulse with nf_cle high, nf_ale low, nf_dq_oe high and nf_dq_out equal to wdata[7:0].
- R5: A write to window offset 0x04 produces one nf_we_n pulse with nf_ale high and nf_cle low, carrying wdata[7:0].
- R6: A write to window offset 0x00 produces one nf_we_n pulse with nf_cle and nf_ale low, carrying wdata[7:0].
- R7: A read of window offset 0x00 produces one nf_re_n pulse with nf_dq_oe low. nf_dq_in is sampled in the last low cycle and returned in rdata[7:0], with the upper bits zero. nf_we_n and nf_re_n are never low together.
- R8: Timing register fields: [5:0] strobe-low cycles, [11:6] strobe-high cycles, [17:12] setup cycles. A field value of 0 acts as 1. CLE, ALE and write data stay stable while a strobe is low.
- R9: host_ack is a one-cycle pulse. A register access acknowledges on the first clock edge that samples the request. A flash access acknowledges setup+low+high edges after that.
- R10: An access to a bank window whose chip-enable bit is clear toggles no strobe and acknowledges on the first edge. A data-port read in that case returns 0xFF.
- R11: Reads of the command or address ports, and any access to an unmapped offset, toggle no strobe, read 0 and acknowledge on the first edge. Timing register bits above 17 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Access request, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Byte address of the access |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ack |
| nf_ce_n | output | 4 | Active-low chip enable per bank |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_wp_n | output | 1 | Write protect, active low |
| nf_dq_out | output | 8 | Byte driven toward the flash |
| nf_dq_oe | output | 1 | Drive enable for nf_dq_out |
| nf_dq_in | input | 8 | Byte returned by the flash |
| nf_rb_n | input | 4 | Ready/busy per bank, low = busy |

## Verification
Each access counts clock edges from the first edge that sees the request up to the edge that raises host_ack. The expected count is 1 for register, gated and unmapped accesses, and 1 + setup + low + high for flash cycles, taken from the timing values the bench has programmed. The counts are sampled 1 ns after each rising edge. A strobe monitor samples on falling edges, measures each strobe's low width and compares CLE, ALE, data, drive enable and chip enables against the queued expectation when the strobe returns high. Before reading the ready bit, the bench waits three edges after changing nf_rb_n, which covers the two synchronizer stages.

// File: rtl/nand_front_pkg.sv
`timescale 1ns/1ps
package nand_front_pkg;

  typedef enum logic [2:0] {
    AK_NONE,
    AK_CTRL,
    AK_TIMING,
    AK_DATA,
    AK_ADDR,
    AK_CMD
  } acc_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_LOW,
    SQ_HIGH
  } seq_state_e;

  typedef struct packed {
    logic       cle;
    logic       ale;
    logic       rd;
    logic [7:0] wbyte;
  } flash_op_t;

  localparam int CTRL_OFS     = 'h000;
  localparam int TIMING_OFS   = 'h004;
  localparam int WIN_BASE     = 'h800;
  localparam int PORT_DATA    = 'h00;
  localparam int PORT_ADDR    = 'h04;
  localparam int PORT_CMD     = 'h08;
  localparam logic [31:0] TIMING_RESET = 32'h0000_1081;

endpackage

// File: rtl/nand_host_decode.sv
`timescale 1ns/1ps
module nand_host_decode
  import nand_front_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_BANKS  = 4,
  parameter int BANK_IDX_W = $clog2(NUM_BANKS)
) (
  input  logic [ADDR_W-1:0]     addr,
  output acc_kind_e             kind,
  output logic [BANK_IDX_W-1:0] bank
);

  localparam int PAGE_W = ADDR_W - 8;
  localparam logic [PAGE_W-1:0] WIN_PAGE = PAGE_W'(WIN_BASE >> 8);
  localparam logic [PAGE_W-1:0] WIN_LAST = PAGE_W'((WIN_BASE >> 8) + NUM_BANKS - 1);

  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] rel;
  logic              in_win;
  logic              unused_rel_hi;

  assign page          = addr[ADDR_W-1:8];
  assign rel           = page - WIN_PAGE;
  assign in_win        = (page >= WIN_PAGE) && (page <= WIN_LAST);
  assign unused_rel_hi = ^rel[PAGE_W-1:BANK_IDX_W];

  always_comb begin
    kind = AK_NONE;
    bank = rel[BANK_IDX_W-1:0];
    if (addr == ADDR_W'(CTRL_OFS)) begin
      kind = AK_CTRL;
    end else if (addr == ADDR_W'(TIMING_OFS)) begin
      kind = AK_TIMING;
    end else if (in_win) begin
      case (addr[7:0])
        8'(PORT_DATA): kind = AK_DATA;
        8'(PORT_ADDR): kind = AK_ADDR;
        8'(PORT_CMD):  kind = AK_CMD;
        default:       kind = AK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/nand_ctrl_regs.sv
`timescale 1ns/1ps
module nand_ctrl_regs
  import nand_front_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CE_W      = 8,
  parameter int TF_W      = 6,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_we,
  input  logic                 timing_we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_BANKS-1:0] rb_n_in,
  output logic [NUM_BANKS-1:0] ce_bank,
  output logic                 wp_off,
  output logic                 ready,
  output logic [TF_W-1:0]      low_w,
  output logic [TF_W-1:0]      high_w,
  output logic [TF_W-1:0]      setup_w,
  output logic [DATA_W-1:0]    ctrl_rd,
  output logic [DATA_W-1:0]    timing_rd
);

  localparam int TIM_W = 3 * TF_W;

  logic [CE_W:0]          ctrl_q, ctrl_d;
  logic [TIM_W-1:0]       timing_q, timing_d;
  logic [NUM_BANKS-1:0]   rb_q1, rb_q2;
  logic                   unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:TIM_W];

  always_comb begin
    ctrl_d   = ctrl_q;
    timing_d = timing_q;
    if (ctrl_we)   ctrl_d   = wdata[CE_W:0];
    if (timing_we) timing_d = wdata[TIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= {1'b1, {CE_W{1'b0}}};
      timing_q <= TIMING_RESET[TIM_W-1:0];
    end else begin
      if (ctrl_we)   ctrl_q   <= ctrl_d;
      if (timing_we) timing_q <= timing_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q1 <= '1;
      rb_q2 <= '1;
    end else begin
      rb_q1 <= rb_n_in;
      rb_q2 <= rb_q1;
    end
  end

  assign ce_bank = ctrl_q[NUM_BANKS-1:0];
  assign wp_off  = ctrl_q[CE_W];
  assign ready   = |(ctrl_q[NUM_BANKS-1:0] & rb_q2);
  assign low_w   = timing_q[TF_W-1:0];
  assign high_w  = timing_q[2*TF_W-1:TF_W];
  assign setup_w = timing_q[3*TF_W-1:2*TF_W];

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[CE_W+1:0]  = {ready, ctrl_q};
    timing_rd          = '0;
    timing_rd[TIM_W-1:0] = timing_q;
  end

  // R3: with nothing selected the ready flag must read low
  p_ready_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[NUM_BANKS-1:0] == '0) |-> !ready);

endmodule

// File: rtl/nand_strobe_seq.sv
`timescale 1ns/1ps
module nand_strobe_seq
  import nand_front_pkg::*;
#(
  parameter int TF_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  flash_op_t       op,
  input  logic [TF_W-1:0] low_w,
  input  logic [TF_W-1:0] high_w,
  input  logic [TF_W-1:0] setup_w,
  input  logic [7:0]      dq_in,
  output logic            done,
  output logic [7:0]      rd_byte,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic [7:0]      dq_out,
  output logic            dq_oe
);

  seq_state_e      state_q, state_d;
  logic [TF_W-1:0] cnt_q, cnt_d;
  flash_op_t       op_q, op_d;
  logic [7:0]      rd_q, rd_d;
  logic            adv;

  function automatic logic [TF_W-1:0] eff(input logic [TF_W-1:0] w);
    return (w == '0) ? TF_W'(1) : w;
  endfunction

  assign adv = (state_q != SQ_IDLE) || start;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    rd_d    = rd_q;
    done    = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_SETUP;
          cnt_d   = eff(setup_w);
          op_d    = op;
        end
      end
      SQ_SETUP: begin
        if (cnt_q == TF_W'(1)) begin
          state_d = SQ_LOW;
          cnt_d   = eff(low_w);
        end else begin
          cnt_d = cnt_q - TF_W'(1);
        end
      end
      SQ_LOW: begin
        if (cnt_q == TF_W'(1)) begin
          state_d = SQ_HIGH;
          cnt_d   = eff(high_w);
          if (op_q.rd) rd_d = dq_in;
        end else begin
          cnt_d = cnt_q - TF_W'(1);
        end
      end
      SQ_HIGH: begin
        if (cnt_q == TF_W'(1)) begin
          state_d = SQ_IDLE;
          done    = 1'b1;
        end else begin
          cnt_d = cnt_q - TF_W'(1);
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      rd_q    <= '0;
    end else if (adv) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      rd_q    <= rd_d;
    end
  end

  assign cle     = (state_q != SQ_IDLE) && op_q.cle;
  assign ale     = (state_q != SQ_IDLE) && op_q.ale;
  assign we_n    = !((state_q == SQ_LOW) && !op_q.rd);
  assign re_n    = !((state_q == SQ_LOW) && op_q.rd);
  assign dq_oe   = (state_q != SQ_IDLE) && !op_q.rd;
  assign dq_out  = op_q.wbyte;
  assign rd_byte = rd_q;

  // R5: command and address latches never raised together
  p_cle_ale_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R8: latch lines and write byte hold while the write strobe stays low
  p_low_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable({cle, ale, dq_out}));

endmodule

// File: rtl/nand_port_front.sv
`timescale 1ns/1ps
module nand_port_front
  import nand_front_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int CE_W      = 8,
  parameter int TF_W      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic                 host_ack,
  output logic [DATA_W-1:0]    host_rdata,
  output logic [NUM_BANKS-1:0] nf_ce_n,
  output logic                 nf_cle,
  output logic                 nf_ale,
  output logic                 nf_we_n,
  output logic                 nf_re_n,
  output logic                 nf_wp_n,
  output logic [7:0]           nf_dq_out,
  output logic                 nf_dq_oe,
  input  logic [7:0]           nf_dq_in,
  input  logic [NUM_BANKS-1:0] nf_rb_n
);

  localparam int BANK_IDX_W = $clog2(NUM_BANKS);

  logic [1:0]            rst_pipe;
  logic                  rst_sn;
  acc_kind_e             kind;
  logic [BANK_IDX_W-1:0] bank;
  logic [NUM_BANKS-1:0]  ce_bank;
  logic                  wp_off, ready;
  logic [TF_W-1:0]       low_w, high_w, setup_w;
  logic [DATA_W-1:0]     ctrl_rd, timing_rd;
  logic                  accept, bank_on, need_cycle;
  logic                  ctrl_we, timing_we;
  flash_op_t             op;
  logic                  seq_done;
  logic [7:0]            seq_rd;
  logic                  busy_q, busy_d, ack_q, ack_d;
  logic [DATA_W-1:0]     rdata_q, rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  nand_host_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_IDX_W(BANK_IDX_W)
  ) u_decode (
    .addr(host_addr), .kind(kind), .bank(bank)
  );

  nand_ctrl_regs #(
    .NUM_BANKS(NUM_BANKS), .CE_W(CE_W), .TF_W(TF_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sn), .ctrl_we(ctrl_we), .timing_we(timing_we),
    .wdata(host_wdata), .rb_n_in(nf_rb_n), .ce_bank(ce_bank),
    .wp_off(wp_off), .ready(ready), .low_w(low_w), .high_w(high_w),
    .setup_w(setup_w), .ctrl_rd(ctrl_rd), .timing_rd(timing_rd)
  );

  assign accept     = host_req && !busy_q && !ack_q;
  assign bank_on    = ce_bank[bank];
  assign need_cycle = accept && bank_on &&
                      ((kind == AK_DATA) ||
                       (host_we && ((kind == AK_ADDR) || (kind == AK_CMD))));
  assign ctrl_we    = accept && host_we && (kind == AK_CTRL);
  assign timing_we  = accept && host_we && (kind == AK_TIMING);

  always_comb begin
    op.cle   = (kind == AK_CMD);
    op.ale   = (kind == AK_ADDR);
    op.rd    = !host_we;
    op.wbyte = host_wdata[7:0];
  end

  nand_strobe_seq #(.TF_W(TF_W)) u_seq (
    .clk(clk), .rst_n(rst_sn), .start(need_cycle), .op(op),
    .low_w(low_w), .high_w(high_w), .setup_w(setup_w), .dq_in(nf_dq_in),
    .done(seq_done), .rd_byte(seq_rd), .cle(nf_cle), .ale(nf_ale),
    .we_n(nf_we_n), .re_n(nf_re_n), .dq_out(nf_dq_out), .dq_oe(nf_dq_oe)
  );

  always_comb begin
    busy_d  = busy_q;
    ack_d   = 1'b0;
    rdata_d = rdata_q;
    if (accept) begin
      if (need_cycle) begin
        busy_d = 1'b1;
      end else begin
        ack_d   = 1'b1;
        rdata_d = '0;
        if (!host_we) begin
          case (kind)
            AK_CTRL:   rdata_d = ctrl_rd;
            AK_TIMING: rdata_d = timing_rd;
            AK_DATA:   rdata_d = DATA_W'(8'hFF);
            default:   rdata_d = '0;
          endcase
        end
      end
    end else if (busy_q && seq_done) begin
      busy_d  = 1'b0;
      ack_d   = 1'b1;
      rdata_d = DATA_W'(seq_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q  <= 1'b0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
    end
  end

  assign host_ack   = ack_q;
  assign host_rdata = rdata_q;
  assign nf_ce_n    = ~ce_bank;
  assign nf_wp_n    = wp_off;

  // R9: completion lasts exactly one cycle
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    host_ack |=> !host_ack);

  // R7: at most one strobe low at a time
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({~nf_we_n, ~nf_re_n}));

  // R10: strobes stay idle unless a flash access is in flight
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy_q |-> (nf_we_n && nf_re_n));

endmodule

// File: tb/nand_port_front_bench.sv
`timescale 1ns/1ps
module nand_port_front_bench;

  typedef struct {
    bit       cle;
    bit       ale;
    bit       rd;
    bit [7:0] b;
    int       lw;
    bit [3:0] ce_n;
  } exp_t;

  logic        clk, rst_n;
  logic        host_req, host_we;
  logic [11:0] host_addr;
  logic [31:0] host_wdata;
  logic        host_ack;
  logic [31:0] host_rdata;
  logic [3:0]  nf_ce_n;
  logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, nf_dq_oe;
  logic [7:0]  nf_dq_out, nf_dq_in;
  logic [3:0]  nf_rb_n;

  int   checks = 0;
  int   fails  = 0;
  bit   finished = 0;
  exp_t sb[$];
  int   mS = 1, mL = 1, mH = 2;
  bit [3:0] m_ce_n = 4'hF;

  nand_port_front u_nand_port_front (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
    .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_wp_n(nf_wp_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
    .nf_dq_in(nf_dq_in), .nf_rb_n(nf_rb_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per completed strobe
  bit       prev_low = 0;
  int       lowcnt = 0;
  bit       c_cle, c_ale, c_rd, c_oe;
  bit [7:0] c_dq;
  bit [3:0] c_ce;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nf_we_n || !nf_re_n) begin
        lowcnt++;
        c_cle = nf_cle; c_ale = nf_ale; c_rd = !nf_re_n;
        c_oe  = nf_dq_oe; c_dq = nf_dq_out; c_ce = nf_ce_n;
        prev_low = 1;
      end else if (prev_low) begin
        prev_low = 0;
        if (sb.size() == 0) begin
          chk(0, "R10", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          string tag;
          e = sb.pop_front();
          tag = e.rd ? "R7" : (e.cle ? "R4" : (e.ale ? "R5" : "R6"));
          chk(c_cle == e.cle && c_ale == e.ale && c_rd == e.rd &&
              c_oe == !e.rd && c_ce == e.ce_n && (e.rd || c_dq == e.b),
              tag, "strobe fields {cle,ale,rd,oe,ce,dq}",
              {c_cle, c_ale, c_rd, c_oe, c_ce, c_dq},
              {e.cle, e.ale, e.rd, !e.rd, e.ce_n, (e.rd ? c_dq : e.b)});
          chk(lowcnt == e.lw, "R8", "strobe low width", lowcnt, e.lw);
        end
        lowcnt = 0;
      end
    end
  end

  task automatic acc(input bit we, input logic [11:0] a, input logic [31:0] d,
                     input int exp_lat, output logic [31:0] rd);
    int n;
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = a; host_wdata = d;
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!host_ack && n < 500);
    rd = host_rdata;
    chk(n == exp_lat, "R9", $sformatf("ack latency addr %0h", a), n, exp_lat);
    @(negedge clk);
    host_req = 0;
  endtask

  task automatic fl(input bit we, input logic [11:0] a, input logic [7:0] b,
                    output logic [31:0] rd);
    exp_t e;
    e.cle = (a[7:0] == 8'h08); e.ale = (a[7:0] == 8'h04); e.rd = !we;
    e.b = b; e.lw = mL; e.ce_n = m_ce_n;
    sb.push_back(e);
    acc(we, a, {24'h0, b}, 1 + mS + mL + mH, rd);
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    logic [31:0] rd;
    acc(1, 12'h000, v, 1, rd);
    m_ce_n = ~v[3:0];
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    logic [31:0] rd;
    rst_n = 0; host_req = 0; host_we = 0; host_addr = '0; host_wdata = '0;
    nf_dq_in = 8'h00; nf_rb_n = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset pins
    chk(nf_ce_n == 4'hF && nf_wp_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale,
        "R1", "reset pins", {nf_ce_n, nf_wp_n, nf_we_n, nf_re_n, nf_cle, nf_ale},
        {4'hF, 5'b11100});
    acc(0, 12'h000, 0, 1, rd); chk(rd == 32'h100, "R1", "ctrl reset", rd, 32'h100);
    acc(0, 12'h004, 0, 1, rd); chk(rd == 32'h1081, "R1", "timing reset", rd, 32'h1081);

    // R2 chip enable and write protect
    set_ctrl(32'h001);
    chk(nf_ce_n == 4'b1110 && !nf_wp_n, "R2", "ce0 wp low", {nf_ce_n, nf_wp_n}, 5'b11100);
    set_ctrl(32'h101);
    chk(nf_wp_n == 1'b1, "R2", "wp high", nf_wp_n, 1);

    // R3 ready flag
    acc(0, 12'h000, 0, 1, rd); chk(rd == 32'h301, "R3", "ready bank0", rd, 32'h301);
    nf_rb_n = 4'b1110; repeat (3) @(posedge clk);
    acc(0, 12'h000, 0, 1, rd); chk(rd == 32'h101, "R3", "busy bank0", rd, 32'h101);
    set_ctrl(32'h301);
    acc(0, 12'h000, 0, 1, rd); chk(rd == 32'h101, "R2", "bit9 write ignored", rd, 32'h101);
    nf_rb_n = 4'hF; repeat (3) @(posedge clk);

    // R4 R5 R6 R7 flash cycles on bank0
    fl(1, 12'h808, 8'h70, rd);
    fl(1, 12'h804, 8'h12, rd);
    fl(1, 12'h804, 8'h34, rd);
    fl(1, 12'h800, 8'h5A, rd);
    nf_dq_in = 8'hA5;
    fl(0, 12'h800, 8'h00, rd); chk(rd == 32'hA5, "R7", "read byte", rd, 32'hA5);

    // R8 timing fields
    acc(1, 12'h004, (2 << 12) | (1 << 6) | 3, 1, rd);
    mS = 2; mL = 3; mH = 1;
    acc(0, 12'h004, 0, 1, rd); chk(rd == 32'h2043, "R8", "timing readback", rd, 32'h2043);
    fl(1, 12'h808, 8'h90, rd);
    nf_dq_in = 8'h3C;
    fl(0, 12'h800, 8'h00, rd); chk(rd == 32'h3C, "R7", "read byte slow timing", rd, 32'h3C);
    acc(1, 12'h004, 0, 1, rd); mS = 1; mL = 1; mH = 1;
    fl(1, 12'h800, 8'h11, rd);
    // R11 timing upper bits
    acc(1, 12'h004, 32'hFFFF_FFFF, 1, rd);
    acc(0, 12'h004, 0, 1, rd); chk(rd == 32'h3FFFF, "R11", "timing width", rd, 32'h3FFFF);
    mS = 63; mL = 63; mH = 63;
    fl(1, 12'h804, 8'hC3, rd);
    acc(1, 12'h004, 32'h1081, 1, rd); mS = 1; mL = 1; mH = 2;

    // R10 bank gating
    set_ctrl(32'h104);
    acc(0, 12'h800, 0, 1, rd); chk(rd == 32'hFF, "R10", "unselected read", rd, 32'hFF);
    acc(1, 12'h808, 32'hFF, 1, rd);
    fl(1, 12'hA08, 8'hFF, rd);
    set_ctrl(32'h100);
    acc(0, 12'hA00, 0, 1, rd); chk(rd == 32'hFF, "R10", "none selected read", rd, 32'hFF);
    acc(0, 12'h000, 0, 1, rd); chk(rd == 32'h100, "R3", "ready none selected", rd, 32'h100);

    // R11 non-data reads and unmapped offsets
    set_ctrl(32'h108);
    acc(0, 12'hB08, 0, 1, rd); chk(rd == 32'h0, "R11", "cmd port read", rd, 0);
    acc(0, 12'hB04, 0, 1, rd); chk(rd == 32'h0, "R11", "addr port read", rd, 0);
    acc(0, 12'h040, 0, 1, rd); chk(rd == 32'h0, "R11", "unmapped read", rd, 0);
    acc(1, 12'h3F0, 32'h55, 1, rd);
    fl(1, 12'hB00, 8'h66, rd);
    nf_rb_n = 4'b0111; repeat (3) @(posedge clk);
    acc(0, 12'h000, 0, 1, rd); chk(rd == 32'h108, "R3", "busy bank3", rd, 32'h108);

    repeat (5) @(posedge clk);
    chk(sb.size() == 0, "R10", "missing strobes", sb.size(), 0);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule